// File: doc/BRIEF.md
# I2C Controller Interrupt Aggregator

This block gathers the event pulses of an I2C controller and turns them into interrupt requests for a processor. Seven basic conditions each have a sticky status flag and an enable bit: transmit-ready, receive-ready, register-access-ready, no-acknowledge, arbitration-lost, stop-detected and addressed-as-slave. The flag is set whenever its event pulses, whether or not the source is enabled, so software can poll it. A fixed-priority arbiter picks the most urgent pending and enabled source and reports it as a 3-bit source code. Any pending and enabled source raises the basic interrupt line.

Two FIFO conditions sit apart from the basic sources. One compares the transmit FIFO fill level with a programmable threshold, and the other does the same for the receive FIFO. Each condition has its own enable bit. Their enabled conditions are ORed onto a second interrupt line that is independent of the basic line. Software reaches status, enables, thresholds and the source code through a four-entry register port. Reads are combinational. When the module-enable input is low, all status is cleared and events are ignored.

Top module: `i2cIrqAgg`

## Requirements
- R1: An event pulse on source bit i (bit 0 arbitration-lost, 1 no-acknowledge, 2 register-access-ready, 3 receive-ready, 4 transmit-ready, 5 stop-detected, 6 addressed-as-slave) sets status flag i on the next clock edge, whatever the enable state. The flags read back in bits [6:0] of register 0.
- R2: `basicIrq` is high exactly when at least one status flag and its matching enable bit are both set.
- R3: Register 3 bits [2:0] return the source code, which is the bit index plus 1 of the lowest-indexed source that is both flagged and enabled, or 0 when no source is. Bit 0 therefore has the highest priority.
- R4: A read of register 3 that reports a nonzero code clears the reported flag on the next edge. Codes 4 (receive-ready) and 5 (transmit-ready) are the exception: their flags stay set.
- R5: Writing register 0 clears each flag whose data bit in [6:0] is 1 and leaves the flags whose bit is 0 untouched. An event on the same flag in the same cycle wins over the clear.
- R6: Register 0 bit 8 reads 1 while `txLevel` is at or below the transmit threshold, and bit 9 reads 1 while `rxLevel` is at or above the receive threshold. Thresholds run from 0 to 16.
- R7: `fifoIrq` equals (bit 8 condition AND transmit FIFO enable) OR (bit 9 condition AND receive FIFO enable). It does not depend on the basic enables.
- R8: While `modEnable` is low, all flags clear on the next edge and stay clear, events are ignored, and both FIFO conditions read 0. Both interrupt lines are then low.
- R9: Register 1 holds the basic enables in [6:0], the transmit FIFO enable in bit 8 and the receive FIFO enable in bit 9. Register 2 holds the transmit threshold in [4:0] and the receive threshold in [12:8]. Both registers read back what was written, and unused bits read 0.
- R10: After `rstN` is asserted, all flags, enables and thresholds are 0, both interrupt lines are low and the source code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modEnable | input | 1 | Module enable; low clears all status |
| evtPulse | input | 7 | One-cycle event pulses, one per basic source |
| txLevel | input | 5 | Transmit FIFO fill level |
| rxLevel | input | 5 | Receive FIFO fill level |
| regSel | input | 2 | Register select: 0 status, 1 enable, 2 threshold, 3 source |
| regWrite | input | 1 | Write strobe |
| regRead | input | 1 | Read strobe (read side effects) |
| regWData | input | 16 | Write data |
| regRData | output | 16 | Read data for the selected register, combinational |
| basicIrq | output | 1 | Combined basic interrupt request |
| fifoIrq | output | 1 | FIFO threshold interrupt request |

## Verification
The bench pulses every source at once and then reads the source code repeatedly. This shows the priority order and the rule that receive-ready and transmit-ready survive a read. A design with the priority reversed would report code 7 first. A design that cleared on every read would move past code 4. The bench also puts a write-one clear and an event on the same flag in the same cycle; a design where the clear wins would lose that event. It drives the FIFO levels exactly at thresholds 0 and 16, where an off-by-one comparison flips bit 8 or bit 9. It drops `modEnable` while events arrive; a design that did not gate events there would leave flags and interrupt lines set.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NSRC  = 7;
  localparam int CODEW = $clog2(NSRC + 1);

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_ENABLE = 2'd1;
  localparam logic [1:0] ADDR_THRESH = 2'd2;
  localparam logic [1:0] ADDR_SOURCE = 2'd3;

  localparam int TX_FIFO_BIT = 8;
  localparam int RX_FIFO_BIT = 9;
  localparam int RX_THR_LSB  = 8;

  // flags that survive a source-code read (receive-ready, transmit-ready)
  localparam logic [NSRC-1:0] KEEP_ON_READ = 7'b0011000;

  typedef struct packed {
    logic [NSRC-1:0] clrMask;
    logic            wrEnable;
    logic            wrThresh;
  } ctlStrobe_t;
endpackage

// File: rtl/i2cIrqCtl.sv
module i2cIrqCtl
  import i2c_irq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]       regSel,
  input  logic             regWrite,
  input  logic             regRead,
  input  logic [DW-1:0]    regWData,
  input  logic [NSRC-1:0]  pending,
  output ctlStrobe_t       strobe,
  output logic [CODEW-1:0] srcCode
);
  logic srcRead;

  // fixed priority: lowest index wins, code = index + 1
  always_comb begin
    srcCode = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) srcCode = CODEW'(i + 1);
    end
  end

  assign srcRead = regRead && (regSel == ADDR_SOURCE);

  always_comb begin
    strobe          = '0;
    strobe.wrEnable = regWrite && (regSel == ADDR_ENABLE);
    strobe.wrThresh = regWrite && (regSel == ADDR_THRESH);
    if (regWrite && (regSel == ADDR_STATUS)) strobe.clrMask = regWData[NSRC-1:0];
    for (int i = 0; i < NSRC; i++) begin
      if (srcRead && (srcCode == CODEW'(i + 1)) && !KEEP_ON_READ[i])
        strobe.clrMask[i] = 1'b1;
    end
  end
endmodule

// File: rtl/i2cIrqDp.sv
module i2cIrqDp
  import i2c_irq_pkg::*;
#(
  parameter int LVLW = 5,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modEnable,
  input  logic [NSRC-1:0] evtPulse,
  input  logic [LVLW-1:0] txLevel,
  input  logic [LVLW-1:0] rxLevel,
  input  ctlStrobe_t      strobe,
  input  logic [DW-1:0]   regWData,
  output logic [NSRC-1:0] statusFlags,
  output logic [NSRC-1:0] basicEn,
  output logic            txFifoEn,
  output logic            rxFifoEn,
  output logic [LVLW-1:0] txThr,
  output logic [LVLW-1:0] rxThr,
  output logic            txFifoFlag,
  output logic            rxFifoFlag,
  output logic [NSRC-1:0] pending,
  output logic            fifoIrq
);
  // one sticky flag per source; set beats clear, module disable beats both
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   statusFlags[i] <= 1'b0;
      else if (!modEnable)         statusFlags[i] <= 1'b0;
      else if (evtPulse[i])        statusFlags[i] <= 1'b1;
      else if (strobe.clrMask[i])  statusFlags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      basicEn  <= '0;
      txFifoEn <= 1'b0;
      rxFifoEn <= 1'b0;
    end else if (strobe.wrEnable) begin
      basicEn  <= regWData[NSRC-1:0];
      txFifoEn <= regWData[TX_FIFO_BIT];
      rxFifoEn <= regWData[RX_FIFO_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThr <= '0;
      rxThr <= '0;
    end else if (strobe.wrThresh) begin
      txThr <= regWData[LVLW-1:0];
      rxThr <= regWData[RX_THR_LSB +: LVLW];
    end
  end

  assign txFifoFlag = modEnable && (txLevel <= txThr);
  assign rxFifoFlag = modEnable && (rxLevel >= rxThr);
  assign pending    = statusFlags & basicEn;
  assign fifoIrq    = (txFifoFlag && txFifoEn) || (rxFifoFlag && rxFifoEn);
endmodule

// File: rtl/i2cIrqAgg.sv
module i2cIrqAgg
  import i2c_irq_pkg::*;
#(
  parameter int LVLW = 5,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modEnable,
  input  logic [6:0]      evtPulse,
  input  logic [LVLW-1:0] txLevel,
  input  logic [LVLW-1:0] rxLevel,
  input  logic [1:0]      regSel,
  input  logic            regWrite,
  input  logic            regRead,
  input  logic [DW-1:0]   regWData,
  output logic [DW-1:0]   regRData,
  output logic            basicIrq,
  output logic            fifoIrq
);
  ctlStrobe_t       strobe;
  logic [NSRC-1:0]  statusFlags;
  logic [NSRC-1:0]  basicEn;
  logic [NSRC-1:0]  pending;
  logic             txFifoEn;
  logic             rxFifoEn;
  logic             txFifoFlag;
  logic             rxFifoFlag;
  logic [LVLW-1:0]  txThr;
  logic [LVLW-1:0]  rxThr;
  logic [CODEW-1:0] srcCode;

  i2cIrqCtl #(.DW(DW)) u_ctl (
    .regSel   (regSel),
    .regWrite (regWrite),
    .regRead  (regRead),
    .regWData (regWData),
    .pending  (pending),
    .strobe   (strobe),
    .srcCode  (srcCode)
  );

  i2cIrqDp #(.LVLW(LVLW), .DW(DW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .modEnable   (modEnable),
    .evtPulse    (evtPulse),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .strobe      (strobe),
    .regWData    (regWData),
    .statusFlags (statusFlags),
    .basicEn     (basicEn),
    .txFifoEn    (txFifoEn),
    .rxFifoEn    (rxFifoEn),
    .txThr       (txThr),
    .rxThr       (rxThr),
    .txFifoFlag  (txFifoFlag),
    .rxFifoFlag  (rxFifoFlag),
    .pending     (pending),
    .fifoIrq     (fifoIrq)
  );

  assign basicIrq = |pending;

  always_comb begin
    regRData = '0;
    case (regSel)
      ADDR_STATUS: begin
        regRData[NSRC-1:0]  = statusFlags;
        regRData[TX_FIFO_BIT] = txFifoFlag;
        regRData[RX_FIFO_BIT] = rxFifoFlag;
      end
      ADDR_ENABLE: begin
        regRData[NSRC-1:0]  = basicEn;
        regRData[TX_FIFO_BIT] = txFifoEn;
        regRData[RX_FIFO_BIT] = rxFifoEn;
      end
      ADDR_THRESH: begin
        regRData[LVLW-1:0]           = txThr;
        regRData[RX_THR_LSB +: LVLW] = rxThr;
      end
      default: regRData[CODEW-1:0] = srcCode;
    endcase
  end
endmodule

// File: rtl/i2cIrqAggChk.sv
module i2cIrqAggChk
  import i2c_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             modEnable,
  input logic [NSRC-1:0]  evtPulse,
  input logic [1:0]       regSel,
  input logic             regRead,
  input logic             regWrite,
  input logic             basicIrq,
  input logic             fifoIrq,
  input logic [NSRC-1:0]  statusFlags,
  input logic [CODEW-1:0] srcCode,
  input logic [NSRC-1:0]  clrMask,
  input logic             txFifoEn,
  input logic             rxFifoEn
);
  for (genvar i = 0; i < NSRC; i++) begin : g_evt
    assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
      (evtPulse[i] && modEnable) |=> statusFlags[i]);
  end

  assert_irq_matches_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    basicIrq == (srcCode != '0));

  assert_read_clears_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regSel == ADDR_SOURCE && srcCode == CODEW'(1) && !evtPulse[0])
      |=> !statusFlags[0]);

  assert_rx_ready_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regSel == ADDR_SOURCE && srcCode == CODEW'(4) && modEnable)
      |=> statusFlags[3]);

  assert_one_read_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && !regWrite) |-> $onehot0(clrMask));

  assert_mod_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    !modEnable |=> (statusFlags == '0 && !basicIrq));

  assert_fifo_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoIrq |-> (txFifoEn || rxFifoEn));
endmodule

bind i2cIrqAgg i2cIrqAggChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .modEnable   (modEnable),
  .evtPulse    (evtPulse),
  .regSel      (regSel),
  .regRead     (regRead),
  .regWrite    (regWrite),
  .basicIrq    (basicIrq),
  .fifoIrq     (fifoIrq),
  .statusFlags (statusFlags),
  .srcCode     (srcCode),
  .clrMask     (strobe.clrMask),
  .txFifoEn    (txFifoEn),
  .rxFifoEn    (rxFifoEn)
);

// File: tb/i2cIrqAgg_bench.sv
`timescale 1ns/1ps
module i2cIrqAgg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modEnable = 1'b1;
  logic [6:0]  evtPulse = '0;
  logic [4:0]  txLevel = 5'd8;
  logic [4:0]  rxLevel = 5'd8;
  logic [1:0]  regSel = '0;
  logic        regWrite = 1'b0;
  logic        regRead = 1'b0;
  logic [15:0] regWData = '0;
  logic [15:0] regRData;
  logic        basicIrq;
  logic        fifoIrq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [6:0] mFlags = '0;
  logic [6:0] mEn = '0;
  logic       mTxEn = 1'b0;
  logic       mRxEn = 1'b0;
  logic [4:0] mTxThr = '0;
  logic [4:0] mRxThr = '0;

  always #10 clk = ~clk;

  i2cIrqAgg u_i2cIrqAgg (
    .clk(clk), .rstN(rstN), .modEnable(modEnable), .evtPulse(evtPulse),
    .txLevel(txLevel), .rxLevel(rxLevel), .regSel(regSel), .regWrite(regWrite),
    .regRead(regRead), .regWData(regWData), .regRData(regRData),
    .basicIrq(basicIrq), .fifoIrq(fifoIrq)
  );

  function automatic logic [2:0] expCode(logic [6:0] f, logic [6:0] e);
    logic [2:0] c = 3'd0;
    for (int i = 6; i >= 0; i--) if (f[i] && e[i]) c = 3'(i + 1);
    return c;
  endfunction

  function automatic logic txCond();
    return modEnable && (txLevel <= mTxThr);
  endfunction

  function automatic logic rxCond();
    return modEnable && (rxLevel >= mRxThr);
  endfunction

  function automatic logic [15:0] expRead(logic [1:0] sel);
    logic [15:0] v = '0;
    case (sel)
      2'd0: begin v[6:0] = mFlags; v[8] = txCond(); v[9] = rxCond(); end
      2'd1: begin v[6:0] = mEn; v[8] = mTxEn; v[9] = mRxEn; end
      2'd2: begin v[4:0] = mTxThr; v[12:8] = mRxThr; end
      default: v[2:0] = expCode(mFlags, mEn);
    endcase
    return v;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doOp(string tag, logic me, logic [6:0] ev, logic [4:0] tl, logic [4:0] rl,
                      logic rd, logic wr, logic [1:0] sel, logic [15:0] wd);
    logic [6:0] clr;
    logic [2:0] code;
    @(negedge clk);
    modEnable = me; evtPulse = ev; txLevel = tl; rxLevel = rl;
    regRead = rd; regWrite = wr; regSel = sel; regWData = wd;
    #1;
    check(tag, regRData, expRead(sel));
    check("R2 basicIrq", 16'(basicIrq), 16'(|(mFlags & mEn)));
    check("R7 fifoIrq", 16'(fifoIrq), 16'((txCond() && mTxEn) || (rxCond() && mRxEn)));
    code = expCode(mFlags, mEn);
    @(posedge clk);
    clr = '0;
    if (wr && sel == 2'd0) clr = wd[6:0];
    if (rd && sel == 2'd3 && code != 3'd0 && code != 3'd4 && code != 3'd5) clr[code - 3'd1] = 1'b1;
    if (wr && sel == 2'd1) begin mEn = wd[6:0]; mTxEn = wd[8]; mRxEn = wd[9]; end
    if (wr && sel == 2'd2) begin mTxThr = wd[4:0]; mRxThr = wd[12:8]; end
    mFlags = me ? ((mFlags & ~clr) | ev) : 7'd0;
  endtask

  task automatic idle(string tag, logic [1:0] sel);
    doOp(tag, 1'b1, 7'd0, 5'd8, 5'd8, 1'b0, 1'b0, sel, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R10: reset state of every register
    idle("R10 status", 2'd0);
    idle("R10 enable", 2'd1);
    idle("R10 thresh", 2'd2);
    idle("R10 source", 2'd3);

    // R1: flag sets with enables off, visible in status
    doOp("R1 pulse", 1'b1, 7'b1000100, 5'd8, 5'd8, 1'b0, 1'b0, 2'd0, 16'd0);
    idle("R1 status", 2'd0);
    idle("R1 no irq", 2'd3);

    // R9: enable and threshold readback, unused bits zero
    doOp("R9 wr en", 1'b1, 7'd0, 5'd8, 5'd8, 1'b0, 1'b1, 2'd1, 16'hFFFF);
    idle("R9 en rb", 2'd1);
    doOp("R9 wr thr", 1'b1, 7'd0, 5'd8, 5'd8, 1'b0, 1'b1, 2'd2, 16'hFFFF);
    idle("R9 thr rb", 2'd2);

    // R3/R4: all sources pending, walk the priority order
    doOp("R3 all", 1'b1, 7'h7F, 5'd8, 5'd8, 1'b0, 1'b0, 2'd3, 16'd0);
    for (int k = 0; k < 5; k++)
      doOp("R3 R4 source read", 1'b1, 7'd0, 5'd8, 5'd8, 1'b1, 1'b0, 2'd3, 16'd0);
    idle("R4 rx ready kept", 2'd0);

    // R5: write-one clear, zero bits untouched, set wins over clear
    doOp("R5 w1c", 1'b1, 7'b0010000, 5'd8, 5'd8, 1'b0, 1'b1, 2'd0, 16'h0018);
    idle("R5 after", 2'd0);
    doOp("R5 zero write", 1'b1, 7'd0, 5'd8, 5'd8, 1'b0, 1'b1, 2'd0, 16'h0000);
    idle("R5 after zero", 2'd0);

    // R6/R7: threshold boundaries
    doOp("R6 thr16", 1'b1, 7'd0, 5'd16, 5'd16, 1'b0, 1'b1, 2'd2, 16'h1010);
    doOp("R6 tx eq16", 1'b1, 7'd0, 5'd16, 5'd15, 1'b0, 1'b0, 2'd0, 16'd0);
    doOp("R6 rx eq16", 1'b1, 7'd0, 5'd17, 5'd16, 1'b0, 1'b0, 2'd0, 16'd0);
    doOp("R6 thr0", 1'b1, 7'd0, 5'd0, 5'd0, 1'b0, 1'b1, 2'd2, 16'h0000);
    doOp("R6 tx0", 1'b1, 7'd0, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 16'd0);
    doOp("R6 tx1", 1'b1, 7'd0, 5'd1, 5'd0, 1'b0, 1'b0, 2'd0, 16'd0);
    doOp("R7 basic off", 1'b1, 7'd0, 5'd1, 5'd0, 1'b0, 1'b1, 2'd1, 16'h0300);
    doOp("R7 fifo only", 1'b1, 7'd0, 5'd1, 5'd0, 1'b0, 1'b0, 2'd1, 16'd0);

    // R8: module disable clears and ignores events
    doOp("R8 prep", 1'b1, 7'h7F, 5'd8, 5'd8, 1'b0, 1'b1, 2'd1, 16'h037F);
    doOp("R8 off", 1'b0, 7'h7F, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 16'd0);
    doOp("R8 off hold", 1'b0, 7'h55, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 16'd0);
    idle("R8 back on", 2'd0);

    // random mix checked against the model
    for (int n = 0; n < 600; n++) begin
      logic [6:0]  ev;
      logic [1:0]  sel;
      logic [31:0] op;
      string       tg;
      for (int b = 0; b < 7; b++) ev[b] = ($urandom % 5) == 0;
      sel = 2'($urandom % 4);
      op  = $urandom % 4;
      case (sel)
        2'd0: tg = "R1 R5 R6 status";
        2'd1: tg = "R9 enable";
        2'd2: tg = "R9 thresh";
        default: tg = "R3 R4 source";
      endcase
      doOp(tg, ($urandom % 40) != 0, ev, 5'($urandom % 17), 5'($urandom % 17),
           op == 1, op == 2, sel,
           (sel == 2'd2) ? {3'd0, 5'($urandom % 17), 3'd0, 5'($urandom % 17)} : 16'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule